// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block owns the program counter of a small load/store processor and chooses its next value every clock. The decoder gives it a branch or jump operation code, two register operands, a short signed relative offset and a register jump target. A built-in flag generator forms overflow, carry, negative and zero flags from the operands. Depending on the operation, it either passes operand A through unchanged or forms A minus B.

A condition evaluator tests the flags for the selected operation. The block then registers one of three values as the next PC: the current PC plus one, the current PC plus the sign-extended offset, or the jump target. Signed comparisons are settled from the exclusive-or of the negative and overflow flags, with the zero flag added for the inclusive and strict forms. A subtraction that overflows therefore still gives the right answer. A registered taken flag shows whether the last update left the sequential path.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset, sampled on the rising edge, sets the PC output to 0 and the taken output to 0.
- R2: Operation code 0 (sequential) sets the PC to PC+1 modulo 2^16 on the next edge and clears taken. Operation codes 9 to 15 behave the same way.
- R3: The flag output is {V,C,N,Z} in bits 3 down to 0. For operation codes 4 to 7, the flags describe F = A-B computed as A + ~B + 1. Z is (F==0), N is F[15], C is the carry out of that sum, and V is 1 exactly when the signed difference does not fit in 16 bits. For all other codes, F = A, Z is (A==0), N is A[15], and C and V are 0.
- R4: Code 1 is taken when Z is 1 (A equals zero). Code 2 is taken when Z is 0. Code 3 is taken when N is 1 (A is negative as a signed value).
- R5: Code 6 (signed less-than) is taken when N xor V is 1. Code 5 (signed greater-or-equal) is taken when N xor V is 0. Both give the true signed comparison even when A-B overflows.
- R6: Code 7 (signed less-or-equal) is taken when (N xor V) or Z is 1. Code 4 (signed greater-than) is taken when that term is 0.
- R7: A taken conditional branch (codes 1 to 7) loads PC plus the 6-bit offset sign-extended to 16 bits, modulo 2^16, and sets taken. A branch that is not taken loads PC+1 and clears taken.
- R8: Code 8 (register jump) loads the jump target input unchanged, without adding 1, and sets taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Branch or jump operation code |
| opnd_a_i | input | 16 | Register operand A |
| opnd_b_i | input | 16 | Register operand B |
| ofs_i | input | 6 | Signed relative branch offset |
| jmp_tgt_i | input | 16 | Register jump target |
| pc_o | output | 16 | Registered program counter |
| taken_o | output | 1 | Registered: last update left the sequential path |
| flags_o | output | 4 | Flags {V,C,N,Z} for the current operands |

## Verification
Random operands are paired with every operation code. This separates the signed-comparison decisions from plain unsigned or sign-bit tests, because the bench's expected result comes from a direct signed comparison. Directed pairs that overflow on subtraction, such as the most negative value against a positive one, separate the N xor V rule from a test of N alone. Equal operands separate the strict comparisons from the inclusive ones. PC values near the top of the range, combined with negative offsets, expose missing wrap-around or missing sign extension. Unused codes and a reset in the middle of a run check that nothing outside the listed cases moves the PC.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        OP_SEQ  = 4'd0,
        OP_BZ   = 4'd1,
        OP_BNZ  = 4'd2,
        OP_BN   = 4'd3,
        OP_BGT  = 4'd4,
        OP_BGE  = 4'd5,
        OP_BLT  = 4'd6,
        OP_BLE  = 4'd7,
        OP_JMPR = 4'd8
    } npc_op_e;

    localparam logic [3:0] FSEL_PASS = 4'b0000;
    localparam logic [3:0] FSEL_SUB  = 4'b0101;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } npc_flags_t;

endpackage

// File: rtl/npc_flag_gen.sv
module npc_flag_gen
    import npc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        fsel_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output npc_flags_t        flags_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   sum_w;
    logic [DATA_W-1:0] res_w;

    always_comb begin
        sum_w   = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
        flags_o = '0;
        if (fsel_i == FSEL_SUB) begin
            res_w     = sum_w[DATA_W-1:0];
            flags_o.c = sum_w[DATA_W];
            flags_o.v = (a_i[MSB] != b_i[MSB]) && (res_w[MSB] != a_i[MSB]);
        end else begin
            res_w = a_i;
        end
        flags_o.n = res_w[MSB];
        flags_o.z = (res_w == '0);
    end

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  logic [3:0] op_i,
    input  npc_flags_t flags_i,
    output logic [3:0] fsel_o,
    output logic       take_o,
    output logic       jump_o
);
    logic lt_w;

    always_comb begin
        lt_w   = flags_i.n ^ flags_i.v;
        fsel_o = FSEL_PASS;
        take_o = 1'b0;
        jump_o = 1'b0;
        case (op_i)
            OP_BZ:   take_o = flags_i.z;
            OP_BNZ:  take_o = ~flags_i.z;
            OP_BN:   take_o = flags_i.n;
            OP_BGT:  begin fsel_o = FSEL_SUB; take_o = ~(lt_w | flags_i.z); end
            OP_BGE:  begin fsel_o = FSEL_SUB; take_o = ~lt_w;               end
            OP_BLT:  begin fsel_o = FSEL_SUB; take_o = lt_w;                end
            OP_BLE:  begin fsel_o = FSEL_SUB; take_o = lt_w | flags_i.z;    end
            OP_JMPR: begin take_o = 1'b1; jump_o = 1'b1;                    end
            default: ;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 16,
    parameter int OFS_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] opnd_a_i,
    input  logic [DATA_W-1:0] opnd_b_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [PC_W-1:0]   jmp_tgt_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              taken_o,
    output logic [3:0]        flags_o
);
    localparam int EXT_W = PC_W - OFS_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            taken;
    } npc_state_t;

    npc_state_t state_d, state_q;
    npc_flags_t flags_w;
    logic [3:0] fsel_w;
    logic       take_w, jump_w;
    logic [PC_W-1:0] sext_w;

    npc_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .fsel_i (fsel_w),
        .a_i    (opnd_a_i),
        .b_i    (opnd_b_i),
        .flags_o(flags_w)
    );

    npc_cond_eval u_cond (
        .op_i   (op_i),
        .flags_i(flags_w),
        .fsel_o (fsel_w),
        .take_o (take_w),
        .jump_o (jump_w)
    );

    always_comb begin
        sext_w        = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
        state_d.pc    = state_q.pc + {{(PC_W-1){1'b0}}, 1'b1};
        state_d.taken = 1'b0;
        if (jump_w) begin
            state_d.pc    = jmp_tgt_i;
            state_d.taken = 1'b1;
        end else if (take_w) begin
            state_d.pc    = state_q.pc + sext_w;
            state_d.taken = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign pc_o    = state_q.pc;
    assign taken_o = state_q.taken;
    assign flags_o = flags_w;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 16,
    parameter int OFS_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] opnd_a_i,
    input logic [DATA_W-1:0] opnd_b_i,
    input logic [OFS_W-1:0]  ofs_i,
    input logic [PC_W-1:0]   jmp_tgt_i,
    input logic [PC_W-1:0]   pc_o,
    input logic              taken_o,
    input logic [3:0]        flags_o
);
    logic is_seq, is_cond;
    assign is_seq  = (op_i == 4'd0) || (op_i > 4'd8);
    assign is_cond = (op_i >= 4'd1) && (op_i <= 4'd7);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pc_o == '0) && !taken_o); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        is_seq |=> (pc_o == $past(pc_o) + 1'b1) && !taken_o); // R2

    AST_PASS_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(op_i >= 4'd4 && op_i <= 4'd7) |-> (flags_o[3:2] == 2'b00)); // R3

    AST_BZ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd1) |=> taken_o == ($past(opnd_a_i) == '0)); // R4

    AST_BLT_NXV: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd6) |=> taken_o == ($past(flags_o[1]) ^ $past(flags_o[3]))); // R5

    AST_BLE_EQ: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd7 && opnd_a_i == opnd_b_i) |=> taken_o); // R6

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        is_cond |=> (taken_o ? (pc_o == $past(pc_o + {{(PC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i}))
                             : (pc_o == $past(pc_o) + 1'b1))); // R7

    AST_JUMP_REG: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8) |=> (pc_o == $past(jmp_tgt_i)) && taken_o); // R8

endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i),
    .ofs_i(ofs_i), .jmp_tgt_i(jmp_tgt_i), .pc_o(pc_o), .taken_o(taken_o), .flags_o(flags_o)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = '0;
    logic [15:0] a = '0, b = '0, tgt = '0;
    logic [5:0]  ofs = '0;
    logic [15:0] pc_o;
    logic        taken_o;
    logic [3:0]  flags_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] pc_exp = '0;

    npc_unit u_npc_unit (
        .clk(clk), .rst(rst), .op_i(op), .opnd_a_i(a), .opnd_b_i(b),
        .ofs_i(ofs), .jmp_tgt_i(tgt), .pc_o(pc_o), .taken_o(taken_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] exp_flags(logic [3:0] o, logic [15:0] x, logic [15:0] y);
        logic [15:0] d;
        int sd;
        if (o >= 4'd4 && o <= 4'd7) begin
            d  = x - y;
            sd = int'($signed(x)) - int'($signed(y));
            return {(sd > 32767 || sd < -32768), ({1'b0, x} >= {1'b0, y}), d[15], (d == 16'h0)};
        end
        return {2'b00, x[15], (x == 16'h0)};
    endfunction

    function automatic logic exp_take(logic [3:0] o, logic [15:0] x, logic [15:0] y);
        case (o)
            4'd1: return x == 16'h0;
            4'd2: return x != 16'h0;
            4'd3: return $signed(x) < 0;
            4'd4: return $signed(x) >  $signed(y);
            4'd5: return $signed(x) >= $signed(y);
            4'd6: return $signed(x) <  $signed(y);
            4'd7: return $signed(x) <= $signed(y);
            4'd8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'd1, 4'd2, 4'd3: return "R4";
            4'd5, 4'd6: return "R5";
            4'd4, 4'd7: return "R6";
            4'd8: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check flags, clock, check PC/taken at next negedge
    task automatic step(logic [3:0] o, logic [15:0] x, logic [15:0] y,
                        logic [5:0] f, logic [15:0] t);
        logic tk;
        op = o; a = x; b = y; ofs = f; tgt = t;
        #1;
        chk("R3 flags", {28'h0, flags_o}, {28'h0, exp_flags(o, x, y)});
        tk = exp_take(o, x, y);
        if (o == 4'd8)  pc_exp = t;
        else if (tk)    pc_exp = pc_exp + {{10{f[5]}}, f};   // R7 taken
        else            pc_exp = pc_exp + 16'd1;             // R7 not taken / R2
        @(posedge clk);
        @(negedge clk);
        chk((o >= 4'd1 && o <= 4'd7) ? "R7 pc" : req_of(o), {16'h0, pc_o}, {16'h0, pc_exp});
        chk(req_of(o), {31'h0, taken_o}, {31'h0, tk});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240613));
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc", {16'h0, pc_o}, 32'h0);
        chk("R1 taken", {31'h0, taken_o}, 32'h0);
        rst = 1'b0;
        pc_exp = 16'h0;

        // directed corner cases
        step(4'd8, 16'h0, 16'h0, 6'd0, 16'hFFFF);      // R8 jump to top
        step(4'd0, 16'h0, 16'h0, 6'd0, 16'h0);         // R2 wrap to 0
        step(4'd8, 16'h0, 16'h0, 6'd0, 16'h0010);      // R8
        step(4'd1, 16'h0, 16'h5, 6'h20, 16'h0);        // R4 BZ taken, -32
        step(4'd2, 16'h0, 16'h0, 6'h1F, 16'h0);        // R4 BNZ not taken
        step(4'd3, 16'h8000, 16'h0, 6'h03, 16'h0);     // R4 BN taken
        step(4'd6, 16'h8000, 16'h0001, 6'h02, 16'h0);  // R5 BLT overflow, taken
        step(4'd5, 16'h8000, 16'h0001, 6'h02, 16'h0);  // R5 BGE overflow, not taken
        step(4'd5, 16'h7FFF, 16'hFFFF, 6'h3F, 16'h0);  // R5 BGE overflow, taken
        step(4'd7, 16'h1234, 16'h1234, 6'h04, 16'h0);  // R6 BLE equal, taken
        step(4'd4, 16'h1234, 16'h1234, 6'h04, 16'h0);  // R6 BGT equal, not taken
        step(4'd4, 16'h0001, 16'hFFFF, 6'h05, 16'h0);  // R6 BGT 1 > -1
        step(4'd12, 16'h0, 16'h0, 6'h10, 16'hABCD);    // R2 unused code acts sequential
        step(4'd15, 16'h0, 16'h0, 6'h3F, 16'hABCD);    // R2 unused code

        // constrained random
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] x, y;
            x = 16'($urandom);
            y = ($urandom_range(0, 7) == 0) ? x : 16'($urandom);
            if ($urandom_range(0, 9) == 0) x = 16'h0;
            step(4'($urandom_range(0, 15)), x, y, 6'($urandom), 16'($urandom));
        end

        // mid-run reset
        op = 4'd8; tgt = 16'h4321; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc", {16'h0, pc_o}, 32'h0);
        chk("R1 taken", {31'h0, taken_o}, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule